// File: doc/BRIEF.md
# Board Power-Up Sequencer

This block brings up three board supply rails in order and keeps them up. It drives one enable per rail and watches one power-good input per rail. A 1.8 V core rail comes up first. A 3.3 V mezzanine rail and an adjustable mezzanine rail come up together after it. The three select outputs of the adjustable regulator are tied to the code for 1.8 V. The block raises the reference oscillator enable only when all rails are good. Only then does it hand the active-low FPGA program-request line to a debounced push button.

The machine has four named states, and its 2-bit state code goes to a status LED driver. ST_IDLE (00) has every rail off and always moves to ST_RAIL1 on the next edge. ST_RAIL1 (01) enables the core rail and moves to ST_RAIL2 once core power-good is seen. ST_RAIL2 (10) enables all three rails and moves to ST_READY once both mezzanine power-goods are seen. It falls back to ST_IDLE if core power-good drops. ST_READY (11) keeps all rails on, enables the oscillator and passes the button through to the program-request line. It falls back to ST_IDLE if any power-good drops.

Each stage has a timeout counter. When the timeout expires the machine stays in the stage and raises a fault flag. Power-good inputs and the button are each synchronised with two flip-flops before use.

Top module: `board_power_seq`

## Requirements
- R1: While reset is asserted and right after it, the state code is 00, all rail enables and osc_en are low, prog_req_n is low and seq_fault is low.
- R2: ST_IDLE moves to ST_RAIL1 (code 01) on the next clock edge unconditionally; ST_RAIL1 drives core_en high and the two mezzanine enables low.
- R3: In ST_RAIL1, a high core_pg moves the machine to ST_RAIL2 (code 10) on the third edge after the input changes (two synchroniser edges plus the state edge); ST_RAIL2 drives all three rail enables high.
- R4: ST_RAIL2 moves to ST_READY (code 11) only when mezz_pg and vadj_pg are both high; either one alone leaves it in ST_RAIL2.
- R5: A low core_pg in ST_RAIL2, or a low on any power-good in ST_READY, returns the machine to ST_IDLE on the third edge after the input falls, after which bring-up restarts.
- R6: When a stage sees no transition for TIMEOUT_CYC edges after it was entered, seq_fault goes high on that edge; the state is held, and seq_fault clears when the stage is left.
- R7: prog_req_n is held low in every state other than ST_READY, whatever the button does.
- R8: In ST_READY, prog_req_n equals the debounced level of btn_n (pressed = 0); a new button level appears on prog_req_n DEBOUNCE_CYC+2 edges after the input changes.
- R9: A button level change that lasts fewer than DEBOUNCE_CYC cycles has no effect on prog_req_n.
- R10: osc_en is high in ST_READY and low in every other state.
- R11: vadj_sel always carries VADJ_SEL, the 1.8 V code (default 3'b100), including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Raw push button, low when pressed |
| core_pg | input | 1 | 1.8 V core rail power-good |
| mezz_pg | input | 1 | 3.3 V mezzanine rail power-good |
| vadj_pg | input | 1 | Adjustable mezzanine rail power-good |
| core_en | output | 1 | 1.8 V core rail enable |
| mezz_en | output | 1 | 3.3 V mezzanine rail enable |
| vadj_en | output | 1 | Adjustable rail enable |
| vadj_sel | output | 3 | Voltage-select code for the adjustable regulator |
| osc_en | output | 1 | Reference oscillator enable |
| prog_req_n | output | 1 | Active-low FPGA program request |
| seq_state | output | 2 | Current state code for the status LED |
| seq_fault | output | 1 | Stage timeout flag |

## Verification
Each result has a fixed latency. A state change caused by a power-good edge shows up on the third clock edge after the input moves. The ST_IDLE to ST_RAIL1 step takes one edge. The fault flag rises TIMEOUT_CYC edges after a stage is entered. A button level reaches prog_req_n DEBOUNCE_CYC+2 edges after it changes. The driver records each expectation with the exact cycle it is due, derived from these counts. The monitor compares it at the falling edge of that cycle. An expectation that is still queued after its cycle has passed counts as a failure, so a late result is caught as well as a wrong one.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RAIL1 = 2'b01,
        ST_RAIL2 = 2'b10,
        ST_READY = 2'b11
    } seq_state_e;

    localparam int NUM_RAILS = 3;
    localparam int PG_CORE   = 0;
    localparam int PG_MEZZ   = 1;
    localparam int PG_VADJ   = 2;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwrseq_debounce.sv
module pwrseq_debounce #(
    parameter int   HOLD_CYC = 16,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic          stable_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable_q <= RST_VAL;
            cnt_q    <= '0;
        end else if (din == stable_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            stable_q <= din;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = stable_q;

    // R9
    db_accept_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stable_q != $past(stable_q)) |-> ($past(cnt_q) == LAST));

    // R9
    db_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clr)           cnt_q <= '0;
        else if (cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == TOP);

    // R6
    tmr_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

    // R6
    tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/board_power_seq.sv
module board_power_seq
    import pwrseq_pkg::*;
#(
    parameter int         TIMEOUT_CYC  = 100000,
    parameter int         DEBOUNCE_CYC = 50000,
    parameter int         SYNC_STAGES  = 2,
    parameter logic [2:0] VADJ_SEL     = 3'b100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       btn_n,
    input  logic       core_pg,
    input  logic       mezz_pg,
    input  logic       vadj_pg,
    output logic       core_en,
    output logic       mezz_en,
    output logic       vadj_en,
    output logic [2:0] vadj_sel,
    output logic       osc_en,
    output logic       prog_req_n,
    output logic [1:0] seq_state,
    output logic       seq_fault
);
    seq_state_e           state_q, state_d;
    logic [NUM_RAILS-1:0] pg_s;
    logic                 btn_s, btn_db;
    logic                 stage_clr, stage_expired;
    logic                 in_stage;

    pwrseq_sync #(.WIDTH(NUM_RAILS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pg_sync (
        .clk(clk), .rst_n(rst_n), .d({vadj_pg, mezz_pg, core_pg}), .q(pg_s));

    pwrseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
        .clk(clk), .rst_n(rst_n), .d(btn_n), .q(btn_s));

    pwrseq_debounce #(.HOLD_CYC(DEBOUNCE_CYC), .RST_VAL(1'b1)) u_btn_db (
        .clk(clk), .rst_n(rst_n), .din(btn_s), .dout(btn_db));

    pwrseq_timer #(.LIMIT(TIMEOUT_CYC)) u_stage_tmr (
        .clk(clk), .rst_n(rst_n), .clr(stage_clr), .expired(stage_expired));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: a lost rail takes priority over advancing
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_RAIL1;
            ST_RAIL1: if (pg_s[PG_CORE]) state_d = ST_RAIL2;
            ST_RAIL2: begin
                if (!pg_s[PG_CORE])                        state_d = ST_IDLE;
                else if (pg_s[PG_MEZZ] && pg_s[PG_VADJ])   state_d = ST_READY;
            end
            ST_READY: if (!(&pg_s)) state_d = ST_IDLE;
        endcase
    end

    assign stage_clr = (state_d != state_q);

    // Output decode
    always_comb begin
        core_en    = 1'b0;
        mezz_en    = 1'b0;
        vadj_en    = 1'b0;
        osc_en     = 1'b0;
        prog_req_n = 1'b0;
        in_stage   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RAIL1: begin
                core_en  = 1'b1;
                in_stage = 1'b1;
            end
            ST_RAIL2: begin
                core_en  = 1'b1;
                mezz_en  = 1'b1;
                vadj_en  = 1'b1;
                in_stage = 1'b1;
            end
            ST_READY: begin
                core_en    = 1'b1;
                mezz_en    = 1'b1;
                vadj_en    = 1'b1;
                osc_en     = 1'b1;
                prog_req_n = btn_db;
            end
        endcase
    end

    assign seq_fault = in_stage && stage_expired;
    assign seq_state = state_q;
    assign vadj_sel  = VADJ_SEL;

    // R2
    idle_to_rail1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q == ST_RAIL1));

    // R5
    ready_loss_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && !(&pg_s)) |=> (state_q == ST_IDLE));

    // R5
    rail2_core_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAIL2 && !pg_s[PG_CORE]) |=> (state_q == ST_IDLE));

    // R6
    rail1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAIL1 && !pg_s[PG_CORE]) |=> (state_q == ST_RAIL1));

    // R7
    prog_release_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_req_n) |-> (state_q == ST_READY));

    // R4
    ready_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && $past(state_q) != ST_READY) |-> ($past(pg_s[PG_MEZZ]) && $past(pg_s[PG_VADJ])));
endmodule

// File: tb/board_power_seq_tb.sv
`timescale 1ns/1ps
module board_power_seq_tb;
    localparam int         TO  = 20;
    localparam int         DB  = 8;
    localparam logic [2:0] SEL = 3'b100;
    localparam logic [1:0] IDL = 2'b00, RL1 = 2'b01, RL2 = 2'b10, RDY = 2'b11;

    logic clk = 1'b0;
    logic rst_n, btn_n, core_pg, mezz_pg, vadj_pg;
    logic core_en, mezz_en, vadj_en, osc_en, prog_req_n, seq_fault;
    logic [2:0] vadj_sel;
    logic [1:0] seq_state;

    always #2.5 clk = ~clk;

    board_power_seq #(.TIMEOUT_CYC(TO), .DEBOUNCE_CYC(DB), .SYNC_STAGES(2), .VADJ_SEL(SEL)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .core_pg(core_pg), .mezz_pg(mezz_pg),
        .vadj_pg(vadj_pg), .core_en(core_en), .mezz_en(mezz_en), .vadj_en(vadj_en),
        .vadj_sel(vadj_sel), .osc_en(osc_en), .prog_req_n(prog_req_n),
        .seq_state(seq_state), .seq_fault(seq_fault));

    typedef struct {
        int          at;
        logic [10:0] val;
        string       req;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected packing: {state, fault, core_en, mezz_en, vadj_en, osc_en, prog_req_n, vadj_sel}
    function automatic logic [10:0] mk(logic [1:0] st, logic flt, logic prog);
        logic [3:0] en;
        unique case (st)
            IDL: en = 4'b0000;
            RL1: en = 4'b1000;
            RL2: en = 4'b1110;
            RDY: en = 4'b1111;
        endcase
        return {st, flt, en, (st == RDY) ? prog : 1'b0, SEL};
    endfunction

    // Driver side: queue an expectation due d cycles from now, kept in due order
    task automatic expect_in(int d, logic [1:0] st, logic flt, logic prog, string req);
        item_t it;
        int    pos;
        it.at  = cyc + d;
        it.val = mk(st, flt, prog);
        it.req = req;
        pos = sbq.size();
        for (int i = 0; i < sbq.size(); i++) begin
            if (sbq[i].at > it.at) begin
                pos = i;
                break;
            end
        end
        sbq.insert(pos, it);
    endtask

    task automatic expect_span(int d0, int d1, logic [1:0] st, logic flt, logic prog, string req);
        for (int d = d0; d <= d1; d++) expect_in(d, st, flt, prog, req);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Monitor: pops every item due at this cycle and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0 && sbq[0].at <= cyc) begin
                item_t it;
                logic [10:0] obs;
                it  = sbq.pop_front();
                obs = {seq_state, seq_fault, core_en, mezz_en, vadj_en, osc_en, prog_req_n, vadj_sel};
                n_chk++;
                if (it.at != cyc || obs !== it.val) begin
                    n_err++;
                    $display("FAIL %s cycle %0d: actual=%b expected=%b (due %0d)",
                             it.req, cyc, obs, it.val, it.at);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; btn_n = 1'b1; core_pg = 1'b0; mezz_pg = 1'b0; vadj_pg = 1'b0;
        tick(1);
        // R1 R11: reset state, select code already present
        expect_in(1, IDL, 1'b0, 1'b0, "R1 R11");
        tick(2);

        rst_n = 1'b1;
        // R2: straight to stage one
        expect_in(1, RL1, 1'b0, 1'b0, "R2");
        // R6: no fault before the limit, fault exactly at it, state held
        expect_span(2, TO, RL1, 1'b0, 1'b0, "R6");
        expect_in(TO + 1, RL1, 1'b1, 1'b0, "R6");
        tick(TO + 3);

        core_pg = 1'b1;
        expect_in(2, RL1, 1'b1, 1'b0, "R3");
        // R3: third edge after the input
        expect_in(3, RL2, 1'b0, 1'b0, "R3");
        tick(4);

        mezz_pg = 1'b1;
        // R4: one mezzanine rail alone does not finish
        expect_span(1, 3, RL2, 1'b0, 1'b0, "R4");
        expect_in(TO - 2, RL2, 1'b0, 1'b0, "R6");
        expect_in(TO - 1, RL2, 1'b1, 1'b0, "R6");
        tick(TO + 1);

        vadj_pg = 1'b1;
        expect_in(2, RL2, 1'b1, 1'b0, "R4");
        // R4 R10: ready with oscillator on, fault cleared, button released
        expect_in(3, RDY, 1'b0, 1'b1, "R4 R10");
        tick(4);

        btn_n = 1'b0;
        // R8: press lands after DB+2 edges, not before
        expect_in(DB + 1, RDY, 1'b0, 1'b1, "R8");
        expect_in(DB + 2, RDY, 1'b0, 1'b0, "R8");
        tick(DB + 4);

        btn_n = 1'b1;
        // R9: short release is ignored
        expect_span(1, 2 * DB, RDY, 1'b0, 1'b0, "R9");
        tick(DB - 2);
        btn_n = 1'b0;
        tick(DB + 4);

        btn_n = 1'b1;
        expect_in(DB + 1, RDY, 1'b0, 1'b0, "R8");
        expect_in(DB + 2, RDY, 1'b0, 1'b1, "R8");
        tick(DB + 3);

        mezz_pg = 1'b0;
        expect_in(2, RDY, 1'b0, 1'b1, "R5");
        // R5 R7: restart, program request forced low with the button released
        expect_in(3, IDL, 1'b0, 1'b0, "R5 R7");
        expect_in(4, RL1, 1'b0, 1'b0, "R5");
        expect_in(5, RL2, 1'b0, 1'b0, "R7");
        expect_in(8, RL2, 1'b0, 1'b0, "R4");
        tick(9);

        mezz_pg = 1'b1;
        expect_in(3, RDY, 1'b0, 1'b1, "R4");
        tick(4);

        vadj_pg = 1'b0;
        expect_in(3, IDL, 1'b0, 1'b0, "R5");
        expect_in(4, RL1, 1'b0, 1'b0, "R2");
        expect_in(5, RL2, 1'b0, 1'b0, "R3");
        expect_in(6, RL2, 1'b0, 1'b0, "R4");
        tick(7);

        core_pg = 1'b0;
        // R5: core loss in stage two restarts and waits in stage one
        expect_in(2, RL2, 1'b0, 1'b0, "R5");
        expect_in(3, IDL, 1'b0, 1'b0, "R5");
        expect_in(4, RL1, 1'b0, 1'b0, "R5");
        expect_in(6, RL1, 1'b0, 1'b0, "R2");
        tick(9);

        if (sbq.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sbq.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule